// File: doc/BRIEF.md
# Debug-Port Chip Erase Sequencer

This block sits behind a debug access port. It carries out a whole-device erase when the debugger sets a command bit in a byte-wide control register. The debugger sees progress through a byte-wide status register.

An erase is accepted only under three conditions: the CPU is already held in reset after cold-plug entry, the access-protection input does not lock the debug unit, and no erase is running. Once accepted, the block runs three phases in a fixed order. First it clears volatile memory through a single request/acknowledge handshake with a RAM-clear engine. Next it walks the flash pages in ascending order, one handshake per page with a page-erase engine, and never issues the one reserved one-time-programmable page. Last it erases the code-protection row through a third handshake, which removes the security state.

Completion raises a sticky DONE flag that the debugger clears by writing 1. The CPU reset hold stays asserted after completion and is released only when a device reset is signalled.

Top module: `dbg_erase_seq`

## Requirements
- R1: The control register is at byte offset 0x100 and reads 0. A write with bit 4 set (0x10) requests an erase. The status register is at offset 0x101: bit 0 is DONE, bit 7 is BUSY (an erase is running), and bits 6..1 read 0. Any other offset reads 0.
- R2: An erase request made while `prot_lock` is high is dropped. BUSY stays 0, no engine request is raised and DONE does not change.
- R3: An erase request made while `cpu_hold` is low (no cold-plug entry since reset or since the last device reset) is dropped. `cold_entry` high for one cycle sets `cpu_hold`.
- R4: The phases run as RAM clear, then flash pages, then protection row. At most one of the three requests is high at any time, and each request stays high until its acknowledge is sampled.
- R5: The flash phase issues exactly one request per page, for indices 0 to NUM_PAGES-1 in ascending order, and skips RSV_PAGE.
- R6: DONE becomes 1 and BUSY becomes 0 only after the protection-row acknowledge.
- R7: DONE is write-1-to-clear through status bit 0. The writable clear mask is 0x1F, so a write of 0x1F clears DONE. A write with bit 0 at 0 leaves DONE unchanged.
- R8: A further erase request while BUSY is 1 is ignored. The running erase still issues one RAM clear, one pass of pages and one row erase, and no second run follows.
- R9: Acceptance of a new erase clears DONE in the same cycle that BUSY rises.
- R10: `cpu_hold` stays 1 during an erase and after DONE. A `dev_rst_in` pulse while BUSY is 0 releases it, and a pulse while BUSY is 1 is ignored. A system reset (`rst_n` low) clears DONE and `cpu_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| prot_lock | input | 1 | Access protection locks the debug unit |
| cold_entry | input | 1 | Cold-plug entry seen, start holding the CPU |
| dev_rst_in | input | 1 | Device reset request, releases the CPU hold when idle |
| cpu_hold | output | 1 | Holds the CPU in reset |
| ram_clr_req | output | 1 | Request to the RAM-clear engine |
| ram_clr_ack | input | 1 | Acknowledge from the RAM-clear engine |
| pg_erase_req | output | 1 | Page-erase request |
| pg_erase_addr | output | $clog2(NUM_PAGES) | Page index to erase |
| pg_erase_ack | input | 1 | Page-erase acknowledge |
| prow_erase_req | output | 1 | Protection-row erase request |
| prow_erase_ack | input | 1 | Protection-row erase acknowledge |

## Verification
The bench builds the block with NUM_PAGES=6 and RSV_PAGE=2. That places the reserved page in the middle of the walk, so the skip and the steps on either side of it all occur in one short run, and the expected page list 0,1,3,4,5 is small enough to compare entry by entry. The engine models answer after differing delays, with page delays that depend on the page index, so requests must be held across waits of several lengths. Every run takes only a few dozen cycles, which leaves room for the lockout, restart, clear-mask and reset-release scenarios in sequence.

// File: rtl/dbg_erase_pkg.sv
package dbg_erase_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_RAM   = 2'd1,
      PH_FLASH = 2'd2,
      PH_PROW  = 2'd3
   } phase_e;

   localparam int unsigned CE_BIT   = 4;
   localparam int unsigned DONE_BIT = 0;
   localparam int unsigned BUSY_BIT = 7;
   localparam logic [7:0]  W1C_MASK = 8'h1F;
endpackage

// File: rtl/dbg_erase_regs.sv
module dbg_erase_regs
   import dbg_erase_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 12,
   parameter logic [ADDR_W-1:0]  CTRL_OFS = 'h100,
   parameter logic [ADDR_W-1:0]  STAT_OFS = 'h101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              busy_i,
   input  logic              done_set_i,
   input  logic              start_i,
   output logic              ce_hit_o,
   output logic              done_o
);
   logic       done_q;
   logic [7:0] clr_vec;
   logic [7:0] stat_val;
   logic       unused_wbits;

   assign ce_hit_o     = bus_wen && (bus_addr == CTRL_OFS) && bus_wdata[CE_BIT];
   assign clr_vec      = (bus_wen && (bus_addr == STAT_OFS)) ? (bus_wdata & W1C_MASK) : 8'h00;
   assign unused_wbits = ^clr_vec[7:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               done_q <= 1'b0;
      else if (done_set_i)      done_q <= 1'b1;
      else if (start_i)         done_q <= 1'b0;
      else if (clr_vec[DONE_BIT]) done_q <= 1'b0;
   end

   always_comb begin
      stat_val           = 8'h00;
      stat_val[DONE_BIT] = done_q;
      stat_val[BUSY_BIT] = busy_i;
   end

   assign bus_rdata = (bus_addr == STAT_OFS) ? stat_val : 8'h00;
   assign done_o    = done_q;

   // R7: a status write with bit 0 clear never drops DONE
   p_keep_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !start_i && !(bus_wen && bus_addr == STAT_OFS && bus_wdata[DONE_BIT]) |=> done_q);
   // R9: acceptance clears DONE
   p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !done_q);
endmodule

// File: rtl/dbg_erase_walker.sv
module dbg_erase_walker #(
   parameter int unsigned NUM_PAGES = 8,
   parameter int unsigned RSV_PAGE  = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic                         adv_i,
   output logic [$clog2(NUM_PAGES)-1:0] page_o,
   output logic                         last_o
);
   localparam int unsigned PW    = $clog2(NUM_PAGES);
   localparam logic [PW:0] FIRST = (PW+1)'((RSV_PAGE == 0) ? 1 : 0);
   localparam logic [PW:0] RSV   = (PW+1)'(RSV_PAGE);
   localparam logic [PW:0] LIMIT = (PW+1)'(NUM_PAGES);

   if (NUM_PAGES < 2) begin : g_bad_pages
      $error("dbg_erase_walker: NUM_PAGES must be at least 2");
   end
   if (RSV_PAGE >= NUM_PAGES) begin : g_bad_rsv
      $error("dbg_erase_walker: RSV_PAGE must lie inside the array");
   end

   logic [PW-1:0] page_q;
   logic [PW:0]   step1, nxt;

   assign step1  = {1'b0, page_q} + 1'b1;
   assign nxt    = (step1 == RSV) ? step1 + 1'b1 : step1;
   assign last_o = (nxt >= LIMIT);
   assign page_o = page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                page_q <= '0;
      else if (load_i)           page_q <= FIRST[PW-1:0];
      else if (adv_i && !last_o) page_q <= nxt[PW-1:0];
   end

   // R5: pages only move upward
   p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !last_o && !load_i |=> page_q > $past(page_q));
endmodule

// File: rtl/dbg_erase_fsm.sv
module dbg_erase_fsm
   import dbg_erase_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ram_ack_i,
   input  logic pg_ack_i,
   input  logic prow_ack_i,
   input  logic walk_last_i,
   output logic ram_req_o,
   output logic pg_req_o,
   output logic prow_req_o,
   output logic walk_load_o,
   output logic walk_adv_o,
   output logic done_set_o,
   output logic busy_o
);
   phase_e ph_q, ph_d;

   always_comb begin
      ph_d        = ph_q;
      walk_load_o = 1'b0;
      walk_adv_o  = 1'b0;
      done_set_o  = 1'b0;
      unique case (ph_q)
         PH_IDLE:  if (start_i) ph_d = PH_RAM;
         PH_RAM:   if (ram_ack_i) begin
                      ph_d        = PH_FLASH;
                      walk_load_o = 1'b1;
                   end
         PH_FLASH: if (pg_ack_i) begin
                      if (walk_last_i) ph_d = PH_PROW;
                      else             walk_adv_o = 1'b1;
                   end
         PH_PROW:  if (prow_ack_i) begin
                      ph_d       = PH_IDLE;
                      done_set_o = 1'b1;
                   end
         default:  ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign ram_req_o  = (ph_q == PH_RAM);
   assign pg_req_o   = (ph_q == PH_FLASH);
   assign prow_req_o = (ph_q == PH_PROW);
   assign busy_o     = (ph_q != PH_IDLE);

   // R4: one request at a time, each held until acknowledged
   p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_req_o, pg_req_o, prow_req_o}));
   p_ram_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req_o && !ram_ack_i |=> ram_req_o);
   p_prow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prow_req_o && !prow_ack_i |=> prow_req_o);
   p_ram_then_pg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_req_o) |-> $past(ram_req_o));
endmodule

// File: rtl/dbg_erase_seq.sv
module dbg_erase_seq
   import dbg_erase_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 12,
   parameter logic [ADDR_W-1:0]  CTRL_OFS  = 'h100,
   parameter logic [ADDR_W-1:0]  STAT_OFS  = 'h101,
   parameter int unsigned        NUM_PAGES = 8,
   parameter int unsigned        RSV_PAGE  = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_wen,
   input  logic [7:0]                   bus_wdata,
   output logic [7:0]                   bus_rdata,
   input  logic                         prot_lock,
   input  logic                         cold_entry,
   input  logic                         dev_rst_in,
   output logic                         cpu_hold,
   output logic                         ram_clr_req,
   input  logic                         ram_clr_ack,
   output logic                         pg_erase_req,
   output logic [$clog2(NUM_PAGES)-1:0] pg_erase_addr,
   input  logic                         pg_erase_ack,
   output logic                         prow_erase_req,
   input  logic                         prow_erase_ack
);
   if (CTRL_OFS == STAT_OFS) begin : g_bad_map
      $error("dbg_erase_seq: control and status offsets must differ");
   end

   logic ce_hit, start, busy, done, done_set;
   logic walk_load, walk_adv, walk_last;
   logic hold_q;

   assign start = ce_hit && !prot_lock && hold_q && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hold_q <= 1'b0;
      else if (cold_entry)         hold_q <= 1'b1;
      else if (dev_rst_in && !busy) hold_q <= 1'b0;
   end
   assign cpu_hold = hold_q;

   dbg_erase_regs #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)) u_regs (
      .clk, .rst_n, .bus_addr, .bus_wen, .bus_wdata, .bus_rdata,
      .busy_i(busy), .done_set_i(done_set), .start_i(start),
      .ce_hit_o(ce_hit), .done_o(done)
   );

   dbg_erase_fsm u_fsm (
      .clk, .rst_n, .start_i(start),
      .ram_ack_i(ram_clr_ack), .pg_ack_i(pg_erase_ack), .prow_ack_i(prow_erase_ack),
      .walk_last_i(walk_last),
      .ram_req_o(ram_clr_req), .pg_req_o(pg_erase_req), .prow_req_o(prow_erase_req),
      .walk_load_o(walk_load), .walk_adv_o(walk_adv),
      .done_set_o(done_set), .busy_o(busy)
   );

   dbg_erase_walker #(.NUM_PAGES(NUM_PAGES), .RSV_PAGE(RSV_PAGE)) u_walk (
      .clk, .rst_n, .load_i(walk_load), .adv_i(walk_adv),
      .page_o(pg_erase_addr), .last_o(walk_last)
   );

   // R2: a locked request never starts a run
   p_lock_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ce_hit && prot_lock && !busy |=> !busy);
   // R3: no run without the CPU held
   p_need_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ce_hit && !hold_q && !busy |=> !busy);
   // R5: the reserved page is never requested
   p_skip_rsv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pg_erase_req |-> pg_erase_addr != ($clog2(NUM_PAGES))'(RSV_PAGE));
   // R6: DONE rises only after the row acknowledge
   p_done_after_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(prow_erase_ack));
   // R10: CPU held throughout a run
   p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cpu_hold);
endmodule

// File: tb/dbg_erase_seq_test.sv
module dbg_erase_seq_test;
   localparam int NP  = 6;
   localparam int RSV = 2;
   localparam int PW  = $clog2(NP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic          bus_wen = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          prot_lock = 1'b0, cold_entry = 1'b0, dev_rst_in = 1'b0;
   logic          cpu_hold;
   logic          ram_clr_req, pg_erase_req, prow_erase_req;
   logic          ram_clr_ack = 1'b0, pg_erase_ack = 1'b0, prow_erase_ack = 1'b0;
   logic [PW-1:0] pg_erase_addr;

   int n_chk = 0, n_err = 0;
   int ev = 0, ram_n = 0, pg_n = 0, prow_n = 0, overlap = 0;
   int ram_ev = 0, pg_ev_first = 0, pg_ev_last = 0, prow_ev = 0;
   int pg_log [16];
   int rc = 0, pc = 0, qc = 0;

   always #5 clk = ~clk;

   dbg_erase_seq #(.NUM_PAGES(NP), .RSV_PAGE(RSV)) uut (.*);

   // engine models and request monitor
   initial forever begin
      @(negedge clk);
      if (int'(ram_clr_req) + int'(pg_erase_req) + int'(prow_erase_req) > 1) overlap++;
      if (ram_clr_ack) begin ram_clr_ack = 1'b0; rc = 0; end
      else if (ram_clr_req) begin
         if (rc == 3) begin ram_clr_ack = 1'b1; ev++; ram_ev = ev; ram_n++; end
         else rc++;
      end
      if (pg_erase_ack) begin pg_erase_ack = 1'b0; pc = 0; end
      else if (pg_erase_req) begin
         if (pc == int'(pg_erase_addr) % 3) begin
            pg_erase_ack = 1'b1; ev++;
            if (pg_n == 0) pg_ev_first = ev;
            pg_ev_last = ev;
            if (pg_n < 16) pg_log[pg_n] = int'(pg_erase_addr);
            pg_n++;
         end else pc++;
      end
      if (prow_erase_ack) begin prow_erase_ack = 1'b0; qc = 0; end
      else if (prow_erase_req) begin
         if (qc == 1) begin prow_erase_ack = 1'b1; ev++; prow_ev = ev; prow_n++; end
         else qc++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_cold();
      @(negedge clk); cold_entry = 1'b1;
      @(negedge clk); cold_entry = 1'b0;
   endtask

   task automatic pulse_devrst();
      @(negedge clk); dev_rst_in = 1'b1;
      @(negedge clk); dev_rst_in = 1'b0;
   endtask

   task automatic clear_log();
      ram_n = 0; pg_n = 0; prow_n = 0;
   endtask

   task automatic wait_done(output bit got);
      logic [7:0] s;
      got = 1'b0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         rd(12'h101, s);
         if (s[0]) begin got = 1'b1; break; end
      end
   endtask

   task automatic t_reset();
      logic [7:0] s;
      rd(12'h101, s); chk(s == 8'h00, "R1", "status after reset", s, 0);
      rd(12'h100, s); chk(s == 8'h00, "R1", "control reads 0", s, 0);
      rd(12'h0FF, s); chk(s == 8'h00, "R1", "unmapped offset reads 0", s, 0);
      chk(cpu_hold == 1'b0, "R10", "cpu_hold after reset", cpu_hold, 0);
      chk(!ram_clr_req && !pg_erase_req && !prow_erase_req, "R4", "no request after reset", 0, 0);
   endtask

   task automatic t_no_cold();
      logic [7:0] s;
      clear_log();
      wr(12'h100, 8'h10);
      rd(12'h101, s); chk(s[7] == 1'b0, "R3", "busy without cold entry", s[7], 0);
      repeat (10) @(negedge clk);
      chk(ram_n == 0, "R3", "RAM clears without cold entry", ram_n, 0);
      pulse_cold();
      chk(cpu_hold == 1'b1, "R3", "cold entry sets hold", cpu_hold, 1);
   endtask

   task automatic t_prot();
      logic [7:0] s;
      clear_log();
      prot_lock = 1'b1;
      wr(12'h100, 8'h10);
      rd(12'h101, s); chk(s == 8'h00, "R2", "status after locked request", s, 0);
      repeat (10) @(negedge clk);
      chk(ram_n + pg_n + prow_n == 0, "R2", "engine requests while locked", ram_n + pg_n + prow_n, 0);
      prot_lock = 1'b0;
   endtask

   task automatic check_run(input string tag);
      int k;
      chk(ram_n == 1, "R4", {tag, " RAM clear count"}, ram_n, 1);
      chk(prow_n == 1, "R6", {tag, " row erase count"}, prow_n, 1);
      chk(pg_n == NP - 1, "R5", {tag, " page count"}, pg_n, NP - 1);
      k = 0;
      for (int p = 0; p < NP; p++) begin
         if (p != RSV) begin
            if (k < pg_n) chk(pg_log[k] == p, "R5", {tag, " page order"}, pg_log[k], p);
            k++;
         end
      end
      chk(ram_ev < pg_ev_first, "R4", {tag, " RAM before pages"}, ram_ev, pg_ev_first);
      chk(pg_ev_last < prow_ev, "R4", {tag, " pages before row"}, pg_ev_last, prow_ev);
   endtask

   task automatic t_full();
      logic [7:0] s;
      bit got;
      clear_log();
      wr(12'h100, 8'h10);
      rd(12'h101, s); chk(s == 8'h80, "R1", "busy set on accept", s, 8'h80);
      rd(12'h100, s); chk(s == 8'h00, "R1", "control reads 0 while running", s, 0);
      wait_done(got);
      chk(got, "R6", "done reached", got, 1);
      rd(12'h101, s); chk(s == 8'h01, "R6", "status after completion", s, 8'h01);
      chk(prow_n == 1, "R6", "done only after row ack", prow_n, 1);
      check_run("run1");
      chk(cpu_hold == 1'b1, "R10", "hold kept after done", cpu_hold, 1);
   endtask

   task automatic t_w1c();
      logic [7:0] s;
      bit got;
      wr(12'h101, 8'h00); rd(12'h101, s); chk(s[0] == 1'b1, "R7", "write 0 keeps done", s[0], 1);
      wr(12'h101, 8'h1E); rd(12'h101, s); chk(s[0] == 1'b1, "R7", "bit0 clear keeps done", s[0], 1);
      wr(12'h101, 8'h01); rd(12'h101, s); chk(s == 8'h00, "R7", "write 1 clears done", s, 0);
      clear_log();
      wr(12'h100, 8'h10);
      wait_done(got);
      wr(12'h101, 8'h1F); rd(12'h101, s); chk(s == 8'h00, "R7", "0x1F clears all", s, 0);
   endtask

   task automatic t_restart();
      logic [7:0] s;
      bit got;
      clear_log();
      wr(12'h100, 8'h10);
      wait_done(got);
      rd(12'h101, s); chk(s[0] == 1'b1, "R9", "done set before restart", s[0], 1);
      clear_log();
      wr(12'h100, 8'h10);
      rd(12'h101, s); chk(s == 8'h80, "R9", "restart clears done", s, 8'h80);
      wait_done(got);
      check_run("run_restart");
   endtask

   task automatic t_busy_ignore();
      logic [7:0] s;
      bit got;
      wr(12'h101, 8'h01);
      clear_log();
      wr(12'h100, 8'h10);
      for (int i = 0; i < 200 && pg_n < 2; i++) @(negedge clk);
      wr(12'h100, 8'h10);
      rd(12'h101, s); chk(s == 8'h80, "R8", "second request while busy", s, 8'h80);
      wait_done(got);
      check_run("run_busy");
      repeat (12) @(negedge clk);
      rd(12'h101, s); chk(s == 8'h01, "R8", "no second run", s, 8'h01);
      chk(ram_n == 1, "R8", "single RAM clear", ram_n, 1);
   endtask

   task automatic t_hold();
      logic [7:0] s;
      bit got;
      clear_log();
      wr(12'h100, 8'h10);
      pulse_devrst();
      chk(cpu_hold == 1'b1, "R10", "device reset ignored while busy", cpu_hold, 1);
      wait_done(got);
      chk(cpu_hold == 1'b1, "R10", "hold after done", cpu_hold, 1);
      pulse_devrst();
      chk(cpu_hold == 1'b0, "R10", "device reset releases hold", cpu_hold, 0);
      wr(12'h101, 8'h01);
      wr(12'h100, 8'h10);
      rd(12'h101, s); chk(s == 8'h00, "R3", "request after release dropped", s, 0);
      pulse_cold();
      clear_log();
      wr(12'h100, 8'h10);
      wait_done(got);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      rd(12'h101, s); chk(s == 8'h00, "R10", "system reset clears done", s, 0);
      chk(cpu_hold == 1'b0, "R10", "system reset clears hold", cpu_hold, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_cold();
      t_prot();
      t_full();
      t_w1c();
      t_restart();
      t_busy_ignore();
      t_hold();
      chk(overlap == 0, "R4", "overlapping requests", overlap, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule